// File: doc/BRIEF.md
# Serial ADC Host Controller

This block is the host-side master for a successive-approximation converter that talks over four wires: an active-low chip select, a serial I/O clock, a serial channel address line and a serial result line. A user request carries a 4-bit channel number over a valid/ready handshake. The controller lowers chip select and waits out the device's select recognition time. It then issues a burst of I/O clock pulses that shift the channel number out MSB first while the 10-bit result comes back MSB first. After the burst it raises chip select and holds it high for the conversion time, then returns the result on a valid/ready response port.

The device converts at the end of the burst. Each transaction therefore reads back the conversion started by the transaction before it. The response carries the channel tag of that earlier transaction, and the first response after reset is marked stale. A shared-clock mode is also provided for the case where the device's system clock and I/O clock are one wire. In that mode the burst opens with extra clocks that the device uses to recognise chip select. The I/O clock half period, select setup, conversion wait and lead-clock count are parameters counted in controller cycles.

Top module: `adc_ser_host`

## Requirements
- R1: `cmd_ready_o` is high only while the controller is idle, with chip select high and no response pending. A request that arrives while the controller is busy is held off and is carried out later. It is not dropped.
- R2: The first I/O clock rising edge comes exactly SETUP_CYC + HALF_CYC controller cycles after chip select falls.
- R3: The address line carries channel bit 3, 2, 1 and then 0, stable across the first four address-carrying rising edges. It is 0 at every later rising edge.
- R4: Each I/O clock high and low phase lasts HALF_CYC cycles. A transaction has exactly 10 rising edges in normal mode and 10 + LEAD_CLKS in shared mode.
- R5: Result bit 9 is sampled before the first address-carrying rising edge. Bits 8 down to 0 are each sampled after one of the following falling edges. `rsp_data_o` holds them with bit 9 as the MSB.
- R6: Chip select rises HALF_CYC cycles after the last falling edge. The response becomes valid exactly CONV_CYC cycles after chip select rises.
- R7: `rsp_chan_o` carries the channel of the previous transaction and `rsp_data_o` carries the conversion that transaction started. The first response after reset has `rsp_stale_o` = 1 and `rsp_chan_o` = 0. All later responses have `rsp_stale_o` = 0.
- R8: In shared mode (`shared_clk_i` = 1, sampled when a request is accepted), the LEAD_CLKS leading pulses carry address 0 and capture no result bits.
- R9: Once `rsp_valid_o` is high, it and the response fields stay unchanged until `rsp_ready_i` is high.
- R10: After reset, chip select is high, the I/O clock and address are low, `cmd_ready_o` is 1 and `rsp_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| shared_clk_i | input | 1 | 1 selects shared system/I/O clock mode |
| cmd_valid_i | input | 1 | Request valid |
| cmd_ready_o | output | 1 | Request accepted when high with valid |
| cmd_chan_i | input | 4 | Channel to address |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Response consumed when high with valid |
| rsp_data_o | output | 10 | Result read back during the transaction |
| rsp_chan_o | output | 4 | Channel that result belongs to |
| rsp_stale_o | output | 1 | Result predates any conversion |
| adc_cs_no | output | 1 | Device chip select, active low |
| adc_ioclk_o | output | 1 | Device I/O clock |
| adc_addr_o | output | 1 | Serial channel address to device |
| adc_dout_i | input | 1 | Serial result from device |

## Verification
A behavioural converter in the bench latches the address it actually receives. It returns a value that depends on that address and on its own conversion count, so a wrong address, a lost or misplaced sample, or a broken pipeline tag each shows up as a wrong word one transaction later. The channels used include all-zeros, all-ones and alternating codes, and the returned words include full-scale and zero codes. A back-to-back pair shows that a request made while busy is held off and still served. A run in shared-clock mode shows that the lead pulses shift no address and skip no result bit. Response stalls confirm that the output holds until it is taken.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LOW,
    ST_HIGH,
    ST_TAIL,
    ST_CONV,
    ST_RESP
  } seq_state_e;
endpackage

// File: rtl/adc_host_timer.sv
module adc_host_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;

  // load N: expired_o goes high N-1 cycles later, so the owning state lasts N cycles
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= load_val_i - 1'b1;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  a_r4_load_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (load_val_i != '0));
endmodule

// File: rtl/adc_host_rx.sv
module adc_host_rx #(
  parameter int DATA_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic [DATA_W-1:0] data_o
);
  localparam int NW = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] sh_q;
  logic [NW-1:0]     n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0;
      n_q  <= '0;
    end else if (clr_i) begin
      sh_q <= '0;
      n_q  <= '0;
    end else if (shift_i) begin
      sh_q <= {sh_q[DATA_W-2:0], bit_i};
      n_q  <= n_q + 1'b1;
    end
  end

  assign data_o = sh_q;

  a_r5_no_extra_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |-> (n_q < NW'(DATA_W)));
endmodule

// File: rtl/adc_ser_host.sv
module adc_ser_host
  import adc_host_pkg::*;
#(
  parameter int DATA_W    = 10,
  parameter int ADDR_W    = 4,
  parameter int LEAD_CLKS = 2,
  parameter int HALF_CYC  = 4,
  parameter int SETUP_CYC = 8,
  parameter int CONV_CYC  = 100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shared_clk_i,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [ADDR_W-1:0] cmd_chan_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic [ADDR_W-1:0] rsp_chan_o,
  output logic              rsp_stale_o,
  output logic              adc_cs_no,
  output logic              adc_ioclk_o,
  output logic              adc_addr_o,
  input  logic              adc_dout_i
);
  localparam int T1     = (SETUP_CYC > HALF_CYC) ? SETUP_CYC : HALF_CYC;
  localparam int TMAX   = (CONV_CYC > T1) ? CONV_CYC : T1;
  localparam int CNT_W  = $clog2(TMAX + 1);
  localparam int NPULSE = DATA_W + LEAD_CLKS;
  localparam int PIDX_W = $clog2(NPULSE + 1);
  localparam int AIDX_W = (ADDR_W > 1) ? $clog2(ADDR_W) : 1;

  seq_state_e        state_q;
  logic [PIDX_W-1:0] pidx_q;
  logic [ADDR_W-1:0] chan_q, prev_chan_q;
  logic              stale_q, shared_q;
  logic              cs_n_q, ioclk_q, addr_q;
  logic [DATA_W-1:0] rsp_data_q;
  logic [ADDR_W-1:0] rsp_chan_q;
  logic              rsp_stale_q;

  logic              accept, expired, tm_load;
  logic [CNT_W-1:0]  tm_val;
  logic [PIDX_W-1:0] lead_w, last_w;
  logic              addr_first, addr_next, rx_shift;
  logic [DATA_W-1:0] rx_data;

  function automatic logic pick_addr(input logic [PIDX_W-1:0] p,
                                     input logic [PIDX_W-1:0] ld,
                                     input logic [ADDR_W-1:0] ch);
    logic [AIDX_W-1:0] idx;
    if (p < ld) return 1'b0;
    if ((p - ld) >= PIDX_W'(ADDR_W)) return 1'b0;
    idx = AIDX_W'(ADDR_W - 1) - AIDX_W'(p - ld);
    return ch[idx];
  endfunction

  assign accept      = (state_q == ST_IDLE) && cmd_valid_i;
  assign lead_w      = shared_q ? PIDX_W'(LEAD_CLKS) : '0;
  assign last_w      = PIDX_W'(DATA_W - 1) + lead_w;
  assign addr_first  = pick_addr('0, lead_w, chan_q);
  assign addr_next   = pick_addr(pidx_q + 1'b1, lead_w, chan_q);
  // sample at the end of each low phase that precedes an address-carrying rise
  assign rx_shift    = (state_q == ST_LOW) && expired && (pidx_q >= lead_w);

  always_comb begin
    tm_load = 1'b0;
    tm_val  = CNT_W'(HALF_CYC);
    unique case (state_q)
      ST_IDLE: begin
        tm_load = cmd_valid_i;
        tm_val  = CNT_W'(SETUP_CYC);
      end
      ST_SETUP, ST_LOW, ST_HIGH: tm_load = expired;
      ST_TAIL: begin
        tm_load = expired;
        tm_val  = CNT_W'(CONV_CYC);
      end
      default: ;
    endcase
  end

  adc_host_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tm_load),
    .load_val_i (tm_val),
    .expired_o  (expired)
  );

  adc_host_rx #(.DATA_W(DATA_W)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (accept),
    .shift_i (rx_shift),
    .bit_i   (adc_dout_i),
    .data_o  (rx_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      pidx_q      <= '0;
      chan_q      <= '0;
      prev_chan_q <= '0;
      stale_q     <= 1'b1;
      shared_q    <= 1'b0;
      cs_n_q      <= 1'b1;
      ioclk_q     <= 1'b0;
      addr_q      <= 1'b0;
      rsp_data_q  <= '0;
      rsp_chan_q  <= '0;
      rsp_stale_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (cmd_valid_i) begin
          chan_q   <= cmd_chan_i;
          shared_q <= shared_clk_i;
          pidx_q   <= '0;
          cs_n_q   <= 1'b0;
          state_q  <= ST_SETUP;
        end
        ST_SETUP: if (expired) begin
          addr_q  <= addr_first;
          state_q <= ST_LOW;
        end
        ST_LOW: if (expired) begin
          ioclk_q <= 1'b1;
          state_q <= ST_HIGH;
        end
        ST_HIGH: if (expired) begin
          ioclk_q <= 1'b0;
          if (pidx_q == last_w) begin
            state_q <= ST_TAIL;
          end else begin
            pidx_q  <= pidx_q + 1'b1;
            addr_q  <= addr_next;
            state_q <= ST_LOW;
          end
        end
        ST_TAIL: if (expired) begin
          cs_n_q  <= 1'b1;
          addr_q  <= 1'b0;
          state_q <= ST_CONV;
        end
        ST_CONV: if (expired) begin
          rsp_data_q  <= rx_data;
          rsp_chan_q  <= prev_chan_q;
          rsp_stale_q <= stale_q;
          prev_chan_q <= chan_q;
          stale_q     <= 1'b0;
          state_q     <= ST_RESP;
        end
        ST_RESP: if (rsp_ready_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready_o = (state_q == ST_IDLE);
  assign rsp_valid_o = (state_q == ST_RESP);
  assign rsp_data_o  = rsp_data_q;
  assign rsp_chan_o  = rsp_chan_q;
  assign rsp_stale_o = rsp_stale_q;
  assign adc_cs_no   = cs_n_q;
  assign adc_ioclk_o = ioclk_q;
  assign adc_addr_o  = addr_q;

  // checker state
  logic              ioclk_d_q, conv_seen_q;
  logic [PIDX_W-1:0] rise_cnt_q;
  logic [CNT_W:0]    hi_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ioclk_d_q   <= 1'b0;
      conv_seen_q <= 1'b0;
      rise_cnt_q  <= '0;
      hi_run_q    <= '0;
    end else begin
      ioclk_d_q <= ioclk_q;
      if (rsp_valid_o) conv_seen_q <= 1'b1;
      if (cs_n_q)                    rise_cnt_q <= '0;
      else if (ioclk_q && !ioclk_d_q) rise_cnt_q <= rise_cnt_q + 1'b1;
      if (!cs_n_q)                                   hi_run_q <= '0;
      else if (hi_run_q < (CNT_W+1)'(CONV_CYC))      hi_run_q <= hi_run_q + 1'b1;
    end
  end

  a_r1_ready_only_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o |-> (adc_cs_no && !rsp_valid_o));
  a_r3_addr_stable_at_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_ioclk_o |-> $stable(adc_addr_o));
  a_r4_no_clk_while_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_cs_no |-> !adc_ioclk_o);
  a_r4_pulse_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(adc_cs_no) |-> (rise_cnt_q == (shared_q ? PIDX_W'(NPULSE) : PIDX_W'(DATA_W))));
  a_r6_conv_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(adc_cs_no) && conv_seen_q) |-> (hi_run_q >= (CNT_W+1)'(CONV_CYC)));
  a_r9_rsp_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o && $stable(rsp_data_o) && $stable(rsp_chan_o)));
endmodule

// File: tb/sim_adc_ser_host.sv
module sim_adc_ser_host;
  localparam int HALF  = 4;
  localparam int SETUP = 8;
  localparam int CONV  = 100;
  localparam int LEAD  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic shared_clk = 1'b0;
  logic cmd_valid = 1'b0;
  logic [3:0] cmd_chan = '0;
  logic rsp_ready = 1'b0;
  logic cmd_ready, rsp_valid, rsp_stale, cs_n, ioclk, addr;
  logic [9:0] rsp_data;
  logic [3:0] rsp_chan;
  logic dout = 1'b0;

  always #10 clk = ~clk;

  adc_ser_host u0 (
    .clk_i(clk), .rst_ni(rst_n), .shared_clk_i(shared_clk),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_chan_i(cmd_chan),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_data_o(rsp_data),
    .rsp_chan_o(rsp_chan), .rsp_stale_o(rsp_stale),
    .adc_cs_no(cs_n), .adc_ioclk_o(ioclk), .adc_addr_o(addr), .adc_dout_i(dout)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0, rst_done = 0;
  int lead_cur = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [9:0] conv_val(input logic [3:0] a, input int n);
    int v;
    if (n == 2) return 10'h3ff;
    if (n == 3) return 10'h000;
    v = int'(a) * 61 + n * 37 + 9;
    return v[9:0];
  endfunction

  // behavioural converter
  logic [9:0] dev_res = '0, dev_sh = '0;
  logic [3:0] dev_addr = '0;
  int dev_cnt = 0, dev_conv = 0;

  always @(negedge cs_n) if (rst_done) begin
    dev_cnt = 0;
    dev_sh  = dev_res;
    dout   <= dev_res[9];
  end

  always @(posedge ioclk) if (rst_done && !cs_n) begin
    int v;
    dev_cnt++;
    v = dev_cnt - lead_cur;
    if (v <= 0)      chk(addr == 1'b0, "R8 lead addr", int'(addr), 0);
    else if (v <= 4) dev_addr = {dev_addr[2:0], addr};
    else             chk(addr == 1'b0, "R3 tail addr", int'(addr), 0);
  end

  always @(negedge ioclk) if (rst_done && !cs_n) begin
    int v;
    v = dev_cnt - lead_cur;
    if (v >= 1 && v <= 9) dout <= dev_sh[9-v];
    else if (v == 10) begin
      dev_res = conv_val(dev_addr, dev_conv);
      dev_conv++;
    end
  end

  always @(posedge cs_n) if (rst_done)
    chk(dev_cnt == 10 + lead_cur, "R4 pulse count", dev_cnt, 10 + lead_cur);

  // pin timing monitor
  logic cs_p = 1'b1, clk_p = 1'b0;
  bit in_setup = 0, in_conv = 0, seen_pulse = 0;
  int setup_cnt = 0, conv_cnt = 0, hi_cnt = 0, lo_cnt = 0;

  always @(negedge clk) if (rst_done) begin
    if (cs_p && !cs_n) begin in_setup = 1; setup_cnt = 0; seen_pulse = 0; end
    if (!cs_p && cs_n) begin in_conv = 1; conv_cnt = 0; end
    if (in_setup) begin
      if (ioclk) begin
        chk(setup_cnt == SETUP + HALF, "R2 setup", setup_cnt, SETUP + HALF);
        in_setup = 0;
      end else setup_cnt++;
    end
    if (in_conv) begin
      if (rsp_valid) begin
        chk(conv_cnt == CONV, "R6 conv wait", conv_cnt, CONV);
        in_conv = 0;
      end else conv_cnt++;
    end
    if (!cs_n) begin
      if (ioclk && !clk_p) begin
        if (seen_pulse) chk(lo_cnt == HALF, "R4 low phase", lo_cnt, HALF);
        hi_cnt = 0;
        seen_pulse = 1;
      end
      if (!ioclk && clk_p) begin
        chk(hi_cnt == HALF, "R4 high phase", hi_cnt, HALF);
        lo_cnt = 0;
      end
      if (ioclk) hi_cnt++; else lo_cnt++;
    end else if (!cs_p) begin
      chk(lo_cnt == HALF, "R6 cs rise after last fall", lo_cnt, HALF);
    end
    cs_p  = cs_n;
    clk_p = ioclk;
  end

  // scoreboard
  logic [14:0] exp_q[$];
  logic [3:0] prev_ch = '0;
  bit first = 1;
  int n_sent = 0, n_got = 0, stall = 0;

  task automatic send(input logic [3:0] ch);
    cmd_chan  = ch;
    cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    chk(cs_n && !rsp_valid, "R1 accept only when idle", int'(cs_n), 1);
    @(negedge clk);
    cmd_valid = 1'b0;
    exp_q.push_back({first, prev_ch, (n_sent > 0) ? conv_val(prev_ch, n_sent - 1) : 10'h000});
    first   = 0;
    prev_ch = ch;
    n_sent++;
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || !cmd_ready) @(negedge clk);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (rsp_valid && !rsp_ready) begin
        logic [9:0] d0;
        logic [14:0] e;
        d0 = rsp_data;
        repeat (stall) begin
          @(negedge clk);
          chk(rsp_valid && rsp_data == d0, "R9 hold", int'(rsp_data), int'(d0));
        end
        if (exp_q.size() == 0) chk(0, "R1 unexpected response", 1, 0);
        else begin
          e = exp_q.pop_front();
          chk(rsp_stale == e[14], "R7 stale flag", int'(rsp_stale), int'(e[14]));
          chk(rsp_chan == e[13:10], "R7 channel tag", int'(rsp_chan), int'(e[13:10]));
          if (!e[14]) chk(rsp_data == e[9:0], "R5 data", int'(rsp_data), int'(e[9:0]));
        end
        n_got++;
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1, "R10 cs", int'(cs_n), 1);
    chk(ioclk == 1'b0, "R10 ioclk", int'(ioclk), 0);
    chk(addr == 1'b0, "R10 addr", int'(addr), 0);
    chk(cmd_ready == 1'b1, "R10 ready", int'(cmd_ready), 1);
    chk(rsp_valid == 1'b0, "R10 rsp_valid", int'(rsp_valid), 0);
    rst_n = 1'b1;
    rst_done = 1;
    @(negedge clk);

    send(4'hA);
    drain();
    send(4'h0);
    drain();
    stall = 3;
    send(4'hF);
    drain();
    send(4'h5);
    @(negedge clk);
    chk(cmd_ready == 1'b0, "R1 busy holds off", int'(cmd_ready), 0);
    send(4'h3);
    drain();
    stall = 0;

    shared_clk = 1'b1;
    lead_cur   = LEAD;
    send(4'h9);
    drain();
    send(4'h6);
    drain();
    send(4'hC);
    drain();

    shared_clk = 1'b0;
    lead_cur   = 0;
    send(4'h1);
    drain();
    send(4'h7);
    drain();

    chk(n_got == n_sent, "R1 no request dropped", n_got, n_sent);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", n_got, n_sent);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule